// File: doc/BRIEF.md
# Prescaled Triple Interval Timer

This block holds three up-counting interval timers that share one fractional tick source. Each clock, the host reports how many processor cycles have elapsed. The block scales that count into a phase accumulator and emits at most one timer tick per clock each time the accumulated phase crosses the next tick position. The tick position then moves on by a fixed step of 5498202 scaled units. One cycle is worth 16384 scaled units, so a tick arrives about every 335.58 cycles.

The fast timer (index 2) advances on every tick. A shared 3-bit prescaler also advances on every tick, and the two slow timers (indices 0 and 1) advance only when that prescaler rolls over. Each timer compares its count against an 8-bit target. On a match it restarts from zero and bumps a 4-bit event counter. Software reads the event counters and clears them by reading.

Top module: `tri_interval_timer`

## Requirements
- R1: The k-th tick (k = 1, 2, ...) takes effect on the clock edge after the edge that samples the advance bringing the total cycles since reset, multiplied by 16384, to at least k × 5498202.
- R2: An enabled fast timer (index 2) advances its count by one on every tick.
- R3: A 3-bit prescaler, cleared by reset, advances on every tick whatever the enables are. Slow timers 0 and 1, when enabled, advance only on the ticks where the prescaler wraps to zero, which are ticks 8, 16, 24 and so on after reset.
- R4: When a timer advances and its incremented count is greater than or equal to its effective target, its count becomes 0 and its event counter increments. Otherwise the count keeps the incremented value. A target lowered below the current count causes a restart on the next advance.
- R5: A target value of 0 acts as 256.
- R6: The 4-bit event counters wrap modulo 16.
- R7: A disabled timer keeps its count and event counter unchanged.
- R8: A read (rd_en high) at address 0, 1 or 2 returns event counter 0, 1 or 2 on rd_data in the same cycle, and that counter is cleared at the next clock edge. Address 3, or rd_en low, returns 0.
- R9: A write to address 0 that changes a timer's enable bit from 0 to 1 clears that timer's count and event counter. Writing 1 over an enable that is already 1 clears nothing.
- R10: Writes at address 0 set the enables from wr_data[2:0], with bit i belonging to timer i. Writes at addresses 1, 2 and 3 set the targets of timers 0, 1 and 2. Reset clears the enables, targets, counts, event counters, prescaler and phase.
- R11: At most one tick occurs per clock, and no two ticks fall on consecutive clocks, given that cyc_adv is at most 15 per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_adv | input | ADV_W (4) | Processor cycles elapsed in this clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 enables, 1..3 targets of timers 0..2 |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Event counter read strobe (clears the counter read) |
| rd_addr | input | 2 | Read address: 0..2 selects timer 0..2 |
| rd_data | output | 4 | Event counter value, combinational |

## Verification
The properties assume that each clock's cycle advance, scaled by 16384, stays well below the tick step. The 4-bit cyc_adv width guarantees this, and it is what keeps ticks at least two clocks apart. They also assume that an enable write and a read are single-cycle strobes that never address the same timer in a way that needs ordering beyond "clear, then count". The stimulus drives cyc_adv in chunks of at most 15 and then idles with zero advance for two clocks before any read. As a result, every pending tick has taken effect and no tick coincides with a read, and the expected counts follow directly from the closed-form tick number floor(total × 16384 / 5498202).

// File: rtl/tit_pkg.sv
package tit_pkg;

    localparam int NUM_TMR  = 3;
    localparam int FAST_IDX = 2;
    localparam int CNT_W    = 8;
    localparam int EVT_W    = 4;
    localparam int ADDR_W   = 2;
    localparam int DATA_W   = 8;

    typedef enum logic [ADDR_W-1:0] {
        SEL_ENABLE = 2'd0,
        SEL_TGT0   = 2'd1,
        SEL_TGT1   = 2'd2,
        SEL_TGT2   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             step;
        logic             clr;
        logic             rd_clr;
        logic [CNT_W-1:0] tgt;
    } slice_ctl_t;

    function automatic logic [CNT_W:0] eff_target(input logic [CNT_W-1:0] t);
        if (t == '0) return (CNT_W+1)'(1) << CNT_W;
        return {1'b0, t};
    endfunction

endpackage

// File: rtl/tit_tick_gen.sv
module tit_tick_gen #(
    parameter int ADV_W    = 4,
    parameter int SCALE_SH = 14,
    parameter int STEP     = 5498202,
    parameter int PRE_W    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ADV_W-1:0] cyc_adv,
    output logic             fast_tick,
    output logic             slow_tick
);

    localparam int ACC_W = $clog2(STEP) + 2;
    localparam logic [ACC_W-1:0] STEP_V = ACC_W'(STEP);

    logic [ACC_W-1:0] credit;
    logic [ACC_W-1:0] gain;
    logic [ACC_W-1:0] spend;
    logic [PRE_W-1:0] pre;

    always_comb begin
        gain      = ACC_W'(cyc_adv) << SCALE_SH;
        fast_tick = (credit >= STEP_V);
        spend     = fast_tick ? STEP_V : '0;
        slow_tick = fast_tick && (pre == '1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            credit <= '0;
            pre    <= '0;
        end else begin
            credit <= credit + gain - spend;
            if (fast_tick) pre <= pre + 1'b1;
        end
    end

endmodule

// File: rtl/tit_timer_slice.sv
module tit_timer_slice
    import tit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  slice_ctl_t       ctl,
    output logic [CNT_W-1:0] cnt,
    output logic [EVT_W-1:0] evt
);

    logic [CNT_W:0]   nxt;
    logic             hit;
    logic [EVT_W-1:0] evt_base;

    always_comb begin
        nxt      = {1'b0, cnt} + 1'b1;
        hit      = ctl.step && (nxt >= eff_target(ctl.tgt));
        evt_base = ctl.rd_clr ? '0 : evt;
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            cnt <= '0;
            evt <= '0;
        end else begin
            if (ctl.step) cnt <= hit ? '0 : nxt[CNT_W-1:0];
            evt <= evt_base + EVT_W'(hit);
        end
    end

endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
    import tit_pkg::*;
#(
    parameter int ADV_W    = 4,
    parameter int SCALE_SH = 14,
    parameter int STEP     = 5498202,
    parameter int PRE_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADV_W-1:0]  cyc_adv,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [EVT_W-1:0]  rd_data
);

    logic                              fast_tick;
    logic                              slow_tick;
    logic [NUM_TMR-1:0]                en_q;
    logic [NUM_TMR-1:0][CNT_W-1:0]     tgt_all;
    logic [NUM_TMR-1:0][CNT_W-1:0]     cnt_all;
    logic [NUM_TMR-1:0][EVT_W-1:0]     evt_all;
    logic [NUM_TMR-1:0]                clr_v;
    logic [NUM_TMR-1:0]                rdc_v;
    logic                              en_wr;

    tit_tick_gen #(
        .ADV_W   (ADV_W),
        .SCALE_SH(SCALE_SH),
        .STEP    (STEP),
        .PRE_W   (PRE_W)
    ) u_tick (
        .clk      (clk),
        .rst      (rst),
        .cyc_adv  (cyc_adv),
        .fast_tick(fast_tick),
        .slow_tick(slow_tick)
    );

    assign en_wr = wr_en && (wr_addr == SEL_ENABLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            tgt_all <= '0;
        end else begin
            if (en_wr) en_q <= wr_data[NUM_TMR-1:0];
            for (int i = 0; i < NUM_TMR; i++) begin
                if (wr_en && wr_addr == ADDR_W'(i + 1)) tgt_all[i] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            clr_v[i] = en_wr && wr_data[i] && !en_q[i];
            rdc_v[i] = rd_en && (rd_addr == ADDR_W'(i));
            if (rdc_v[i]) rd_data = evt_all[i];
        end
    end

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        slice_ctl_t ctl;
        logic       src_tick;
        if (g == FAST_IDX) begin : g_fast
            assign src_tick = fast_tick;
        end else begin : g_slow
            assign src_tick = slow_tick;
        end
        assign ctl.step   = en_q[g] && src_tick;
        assign ctl.clr    = clr_v[g];
        assign ctl.rd_clr = rdc_v[g];
        assign ctl.tgt    = tgt_all[g];

        tit_timer_slice u_slice (
            .clk(clk),
            .rst(rst),
            .ctl(ctl),
            .cnt(cnt_all[g]),
            .evt(evt_all[g])
        );
    end

endmodule

// File: rtl/tit_checker.sv
module tit_checker
    import tit_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic                          fast_tick,
    input logic                          slow_tick,
    input logic [NUM_TMR-1:0]            en_q,
    input logic [NUM_TMR-1:0][CNT_W-1:0] tgt_all,
    input logic [NUM_TMR-1:0][CNT_W-1:0] cnt_all,
    input logic [NUM_TMR-1:0][EVT_W-1:0] evt_all,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic                          rd_en,
    input logic [ADDR_W-1:0]             rd_addr,
    input logic [EVT_W-1:0]              rd_data
);

    // R11: ticks never land on consecutive clocks
    assert_tick_spacing_R11: assert property (@(posedge clk) disable iff (rst)
        fast_tick |=> !fast_tick);

    // R3: slow advance only ever happens on a tick
    assert_slow_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
        slow_tick |-> fast_tick);

    // R8: unused read address returns zero
    assert_unused_addr_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == ADDR_W'(NUM_TMR)) |-> (rd_data == '0));

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_chk
        logic tk;
        if (g == FAST_IDX) begin : g_f
            assign tk = fast_tick;
        end else begin : g_s
            assign tk = slow_tick;
        end

        // R4: a match restarts the count
        assert_count_restart_R4: assert property (@(posedge clk) disable iff (rst)
            (en_q[g] && tk && (({1'b0, cnt_all[g]} + 1'b1) >= eff_target(tgt_all[g])))
            |=> (cnt_all[g] == '0));

        // R7: disabled timer holds its event counter
        assert_disabled_hold_R7: assert property (@(posedge clk) disable iff (rst)
            (!en_q[g] && !(rd_en && rd_addr == ADDR_W'(g)) && !(wr_en && wr_addr == SEL_ENABLE))
            |=> $stable(evt_all[g]) && $stable(cnt_all[g]));

        // R8: a read leaves at most the event of that same edge
        assert_read_clear_R8: assert property (@(posedge clk) disable iff (rst)
            (rd_en && rd_addr == ADDR_W'(g)) |=> (evt_all[g] <= EVT_W'(1)));

        // R9: a fresh enable starts from a clean timer
        assert_enable_clear_R9: assert property (@(posedge clk) disable iff (rst)
            $rose(en_q[g]) |-> (cnt_all[g] == '0 && evt_all[g] == '0));
    end

endmodule

bind tri_interval_timer tit_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .fast_tick(fast_tick),
    .slow_tick(slow_tick),
    .en_q     (en_q),
    .tgt_all  (tgt_all),
    .cnt_all  (cnt_all),
    .evt_all  (evt_all),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
);

// File: tb/tri_interval_timer_tb.sv
module tri_interval_timer_tb;

    localparam longint STEP_L  = 5498202;
    localparam longint SCALE_L = 16384;
    localparam int     NVEC    = 9;
    localparam int     WD_MAX  = 150000;

    // {target of timer 2, cycles advanced from reset, expected event count}
    localparam logic [27:0] VEC [NVEC] = '{
        {8'd1, 16'd0,    4'd0},
        {8'd1, 16'd335,  4'd0},
        {8'd1, 16'd336,  4'd1},
        {8'd1, 16'd671,  4'd1},
        {8'd1, 16'd672,  4'd2},
        {8'd1, 16'd3355, 4'd9},
        {8'd1, 16'd3356, 4'd10},
        {8'd3, 16'd3356, 4'd3},
        {8'd4, 16'd3356, 4'd2}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] cyc_adv = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_addr = '0;
    logic [3:0] rd_data;

    int     n_chk  = 0;
    int     n_fail = 0;
    int     n_clk  = 0;
    longint total  = 0;

    always #10 clk = ~clk;

    tri_interval_timer u_dut (
        .clk    (clk),
        .rst    (rst),
        .cyc_adv(cyc_adv),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    always @(posedge clk) begin
        n_clk <= n_clk + 1;
        if (n_clk > WD_MAX) begin
            n_fail = n_fail + 1;
            n_chk  = n_chk + 1;
            $display("FAIL R11 watchdog: clocks %0d expected below %0d", n_clk, WD_MAX);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cyc_adv = '0; wr_en = 1'b0; rd_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        total = 0;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [3:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic advance(input longint n);
        longint left = n;
        while (left > 0) begin
            @(negedge clk);
            cyc_adv = (left > 15) ? 4'd15 : 4'(left);
            total   = total + ((left > 15) ? 15 : left);
            left    = left - ((left > 15) ? 15 : left);
        end
        @(negedge clk);
        cyc_adv = '0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic to_tick(input longint k);
        longint need = (k * STEP_L + SCALE_L - 1) / SCALE_L;
        if (need > total) advance(need - total);
    endtask

    initial begin
        logic [3:0] v;

        // Reset state
        do_reset();
        for (int a = 0; a < 4; a++) begin
            reg_read(2'(a), v);
            check("R10 reset read", v, 4'd0);
        end

        // Vector table: tick placement and target matching on timer 2
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            reg_write(2'd3, VEC[i][27:20]);
            reg_write(2'd0, 8'b100);
            advance(longint'(VEC[i][19:4]));
            reg_read(2'd2, v);
            check("R1/R2/R4 vector", v, VEC[i][3:0]);
        end

        // Prescaler, wrap, disabled timer, read clear
        do_reset();
        reg_write(2'd1, 8'd1);
        reg_write(2'd2, 8'd2);
        reg_write(2'd3, 8'd1);
        reg_write(2'd0, 8'b110);
        to_tick(17);
        reg_read(2'd2, v); check("R6 wrap of fast events", v, 4'd1);
        reg_read(2'd1, v); check("R3 slow timer 1 events", v, 4'd1);
        reg_read(2'd0, v); check("R7 disabled timer 0", v, 4'd0);
        reg_read(2'd2, v); check("R8 cleared by read", v, 4'd0);
        reg_write(2'd0, 8'b111);
        to_tick(24);
        reg_read(2'd0, v); check("R3 prescaler ran while disabled", v, 4'd1);
        reg_read(2'd2, v); check("R2 fast timer ticks 18..24", v, 4'd7);

        // Enable edge behaviour
        do_reset();
        reg_write(2'd3, 8'd3);
        reg_write(2'd0, 8'b100);
        to_tick(7);
        reg_write(2'd0, 8'b100);
        to_tick(9);
        reg_read(2'd2, v); check("R9 rewrite of 1 keeps state", v, 4'd3);
        to_tick(11);
        reg_write(2'd0, 8'b000);
        reg_write(2'd0, 8'b100);
        to_tick(12);
        reg_read(2'd2, v); check("R9 rising enable clears count", v, 4'd0);

        // Target 0 acts as 256
        do_reset();
        reg_write(2'd3, 8'd0);
        reg_write(2'd0, 8'b100);
        to_tick(255);
        reg_read(2'd2, v); check("R5 no event before 256", v, 4'd0);
        to_tick(256);
        reg_read(2'd2, v); check("R5 event at 256", v, 4'd1);

        // Lowered target restarts on the next advance
        do_reset();
        reg_write(2'd3, 8'd5);
        reg_write(2'd0, 8'b100);
        to_tick(3);
        reg_write(2'd3, 8'd2);
        to_tick(4);
        reg_read(2'd2, v); check("R4 greater-or-equal restart", v, 4'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule